// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the effective address of a single-register load or store and carries out the memory access. The offset comes from one of two sources. It is either a 12-bit immediate or a register value passed through a shifter with four shift kinds. The offset is added to or subtracted from the base value. The access then goes out either at the combined address (pre-indexed) or at the untouched base (post-indexed). If writeback is requested, the combined address is returned for the base register in either mode.

The execute stage pulses `start` with the decoded fields and the register values it has already read. The unit issues one request to memory and holds it until `mem_ready`. One cycle later it pulses `done`, together with any register-file write, base writeback, fault or PC-modified indication. If the condition check has already failed, the access is dropped and only `done` is produced. Byte accesses carry their data in bits 7:0. Word data is treated as already assembled little-endian by the memory side.

Top module: `ldst_agu`

## Requirements
- R1: The offset is `imm_off` zero-extended when `imm_sel`=1. Otherwise it is `off_reg` shifted by `shift_amt` according to `shift_type`: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. An amount of 0 means no shift for kind 0, a shift by 32 for kinds 1 and 2, and a one-bit rotate through `carry_in` for kind 3. The offset is added when `up`=1 and subtracted when `up`=0, modulo 2^32.
- R2: `mem_addr` equals base±offset when `pre_index`=1 and equals `base_val` when `pre_index`=0.
- R3: With `writeback`=1, `wb_we` pulses together with `done` and `wb_data` carries base±offset in both indexing modes. With `writeback`=0, `wb_we` stays low.
- R4: `mem_byte` follows `is_byte`. A byte load writes `{24'b0, mem_rdata[7:0]}`, whatever the upper bits of `mem_rdata` hold. A word load writes all 32 bits.
- R5: A completed load pulses `rf_we` with `done`, with `rf_waddr`=`rd_idx` and the loaded data. `pc_modified` pulses with it exactly when `rd_idx`=15. A store never asserts `rf_we`.
- R6: A store drives `mem_we`=1 and `mem_wdata`=`rd_val`. When `rd_idx`=15 and `pc_adj_en`=1, `mem_wdata` is `rd_val`+4 instead.
- R7: A load that sees `mem_fault` at the ready cycle pulses `fault` with `done` and asserts neither `rf_we` nor `wb_we`.
- R8: A `start` with `cond_pass`=0 pulses `done` on the next cycle, issues no request and writes nothing.
- R9: `mem_req` is held, with a stable address, until `mem_ready`. It drops and `done` rises one cycle after the ready cycle. A `start` seen while `mem_req` is high is ignored.
- R10: After reset, `mem_req`, `done`, `rf_we`, `wb_we`, `fault` and `pc_modified` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation issue strobe |
| cond_pass | input | 1 | Condition check result; 0 skips the access |
| is_load | input | 1 | 1 = load, 0 = store |
| is_byte | input | 1 | 1 = byte access, 0 = word |
| pre_index | input | 1 | 1 = access at base±offset, 0 = access at base |
| up | input | 1 | 1 = add offset, 0 = subtract |
| writeback | input | 1 | Return updated address for the base register |
| imm_sel | input | 1 | 1 = immediate offset, 0 = shifted register |
| imm_off | input | 12 | Immediate offset |
| shift_type | input | 2 | Shift kind for the register offset |
| shift_amt | input | 5 | Shift amount |
| carry_in | input | 1 | Carry flag used by rotate-through-carry |
| rd_idx | input | 4 | Transfer register index |
| base_val | input | 32 | Base register value |
| off_reg | input | 32 | Offset register value |
| rd_val | input | 32 | Store source value |
| pc_adj_en | input | 1 | Enables +4 on stores of register 15 |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | 1 = write request |
| mem_byte | output | 1 | 1 = byte-sized request |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_fault | input | 1 | Address not mapped, valid with mem_ready |
| done | output | 1 | Operation complete (one cycle) |
| rf_we | output | 1 | Register-file write for the loaded value |
| rf_waddr | output | 4 | Destination register index |
| rf_wdata | output | 32 | Loaded value |
| wb_we | output | 1 | Base register writeback strobe |
| wb_data | output | 32 | Updated base address |
| pc_modified | output | 1 | Load wrote register 15 |
| fault | output | 1 | Load from unmapped address |

## Verification
The assertions assume the memory side is well behaved. `mem_ready` is never raised unless `mem_req` is high, and `mem_fault` is only considered at the ready cycle. The assertions also assume the issuing stage keeps its operand fields steady for the cycle in which `start` is sampled. The bench memory derives `mem_ready` from `mem_req` through a per-access latency counter and reports a fault only for addresses outside its 64-byte window, so these assumptions hold throughout. Stimulus changes every input only at the falling edge. One deliberate stray `start` is sent during a pending request to exercise the ignore rule.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;
endpackage

// File: rtl/ldst_shifter.sv
module ldst_shifter
  import ldst_pkg::*;
#(
  parameter int DW   = 32,
  parameter int SA_W = $clog2(DW)
) (
  input  logic [DW-1:0]   val,
  input  shift_e          kind,
  input  logic [SA_W-1:0] amt,
  input  logic            carry_in,
  output logic [DW-1:0]   res
);
  localparam logic [SA_W:0] FULL = (SA_W+1)'(DW);
  logic [SA_W:0] back;
  assign back = FULL - {1'b0, amt};

  always_comb begin
    case (kind)
      SH_LSL:  res = val << amt;
      SH_LSR:  res = (amt == '0) ? '0 : (val >> amt);
      SH_ASR:  res = (amt == '0) ? {DW{val[DW-1]}} : DW'($signed(val) >>> amt);
      SH_ROR:  res = (amt == '0) ? {carry_in, val[DW-1:1]}
                                 : ((val >> amt) | (val << back));
      default: res = val;
    endcase
  end
endmodule

// File: rtl/ldst_addr_calc.sv
module ldst_addr_calc #(
  parameter int DW    = 32,
  parameter int IMM_W = 12
) (
  input  logic [DW-1:0]    base,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [DW-1:0]    shifted,
  input  logic             imm_sel,
  input  logic             up,
  input  logic             pre_index,
  output logic [DW-1:0]    acc_addr,
  output logic [DW-1:0]    upd_addr
);
  logic [DW-1:0] offset;
  assign offset   = imm_sel ? DW'(imm_off) : shifted;
  assign upd_addr = up ? (base + offset) : (base - offset);
  assign acc_addr = pre_index ? upd_addr : base;
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IMM_W  = 12,
  parameter int RID_W  = 4,
  parameter int PC_IDX = 15,
  parameter int SA_W   = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cond_pass,
  input  logic             is_load,
  input  logic             is_byte,
  input  logic             pre_index,
  input  logic             up,
  input  logic             writeback,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm_off,
  input  logic [1:0]       shift_type,
  input  logic [SA_W-1:0]  shift_amt,
  input  logic             carry_in,
  input  logic [RID_W-1:0] rd_idx,
  input  logic [DW-1:0]    base_val,
  input  logic [DW-1:0]    off_reg,
  input  logic [DW-1:0]    rd_val,
  input  logic             pc_adj_en,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_byte,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_fault,
  output logic             done,
  output logic             rf_we,
  output logic [RID_W-1:0] rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic             wb_we,
  output logic [DW-1:0]    wb_data,
  output logic             pc_modified,
  output logic             fault
);
  localparam logic [RID_W-1:0] PC_ID    = RID_W'(PC_IDX);
  localparam logic [DW-1:0]    PC_AHEAD = DW'(4);

  logic [DW-1:0] shifted, acc_addr, upd_addr, store_val;

  ldst_shifter #(.DW(DW), .SA_W(SA_W)) u_shift (
    .val      (off_reg),
    .kind     (shift_e'(shift_type)),
    .amt      (shift_amt),
    .carry_in (carry_in),
    .res      (shifted)
  );

  ldst_addr_calc #(.DW(DW), .IMM_W(IMM_W)) u_addr (
    .base      (base_val),
    .imm_off   (imm_off),
    .shifted   (shifted),
    .imm_sel   (imm_sel),
    .up        (up),
    .pre_index (pre_index),
    .acc_addr  (acc_addr),
    .upd_addr  (upd_addr)
  );

  assign store_val = (rd_idx == PC_ID && pc_adj_en) ? (rd_val + PC_AHEAD) : rd_val;

  // Operation context held while the request is outstanding
  logic             ld_q, wb_q;
  logic [RID_W-1:0] rd_q;
  logic [DW-1:0]    upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_byte    <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      done        <= 1'b0;
      rf_we       <= 1'b0;
      rf_waddr    <= '0;
      rf_wdata    <= '0;
      wb_we       <= 1'b0;
      wb_data     <= '0;
      pc_modified <= 1'b0;
      fault       <= 1'b0;
      ld_q        <= 1'b0;
      wb_q        <= 1'b0;
      rd_q        <= '0;
      upd_q       <= '0;
    end else begin
      done        <= 1'b0;
      rf_we       <= 1'b0;
      wb_we       <= 1'b0;
      pc_modified <= 1'b0;
      fault       <= 1'b0;
      if (!mem_req) begin
        if (start) begin
          if (!cond_pass) begin
            done <= 1'b1;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= !is_load;
            mem_byte  <= is_byte;
            mem_addr  <= acc_addr;
            mem_wdata <= store_val;
            ld_q      <= is_load;
            wb_q      <= writeback;
            rd_q      <= rd_idx;
            upd_q     <= upd_addr;
          end
        end
      end else if (mem_ready) begin
        mem_req <= 1'b0;
        done    <= 1'b1;
        if (ld_q && mem_fault) begin
          fault <= 1'b1;
        end else begin
          if (ld_q) begin
            rf_we       <= 1'b1;
            rf_waddr    <= rd_q;
            rf_wdata    <= mem_byte ? {{(DW-8){1'b0}}, mem_rdata[7:0]} : mem_rdata;
            pc_modified <= (rd_q == PC_ID);
          end
          if (wb_q) begin
            wb_we   <= 1'b1;
            wb_data <= upd_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk #(
  parameter int DW     = 32,
  parameter int RID_W  = 4,
  parameter int PC_IDX = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cond_pass,
  input logic             mem_req,
  input logic             mem_ready,
  input logic [DW-1:0]    mem_addr,
  input logic             done,
  input logic             rf_we,
  input logic [RID_W-1:0] rf_waddr,
  input logic             wb_we,
  input logic             fault,
  input logic             pc_modified
);
  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && mem_addr == $past(mem_addr)));

  assert_done_after_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> (done && !mem_req));

  assert_skip_no_access_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !mem_req && !cond_pass) |=> (done && !mem_req && !rf_we && !wb_we));

  assert_fault_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    fault |-> (done && !rf_we && !wb_we));

  assert_pcmod_only_r15_R5: assert property (@(posedge clk) disable iff (rst)
    pc_modified |-> (rf_we && rf_waddr == RID_W'(PC_IDX)));

  assert_rf_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done);

  assert_wb_with_done_R3: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> done);
endmodule

bind ldst_agu ldst_agu_chk #(.DW(DW), .RID_W(RID_W), .PC_IDX(PC_IDX)) u_chk (.*);

// File: tb/sim_ldst_agu.sv
module sim_ldst_agu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        start = 0, cond_pass = 0, is_load = 0, is_byte = 0, pre_index = 0, up = 0;
  logic        writeback = 0, imm_sel = 0, carry_in = 0, pc_adj_en = 0;
  logic [11:0] imm_off = 0;
  logic [1:0]  shift_type = 0;
  logic [4:0]  shift_amt = 0;
  logic [3:0]  rd_idx = 0;
  logic [31:0] base_val = 0, off_reg = 0, rd_val = 0;
  logic        mem_req, mem_we, mem_byte, mem_ready, mem_fault;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, rf_we, wb_we, pc_modified, fault;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata, wb_data;

  int checks = 0, errors = 0;

  ldst_agu u0 (.*);

  // Bench memory: 16 words, bytes 0..63 mapped, latency per access
  logic [31:0] mem [0:15];
  int lat_set = 0, lat_cnt = 0;
  logic [7:0] sel_byte;
  assign sel_byte  = mem[mem_addr[5:2]][{mem_addr[1:0], 3'b000} +: 8];
  assign mem_ready = mem_req && (lat_cnt == 0);
  assign mem_fault = (mem_addr >= 32'd64);
  assign mem_rdata = mem_byte ? {24'hABCDEF, sel_byte} : mem[mem_addr[5:2]];

  always @(posedge clk) begin
    if (!mem_req) lat_cnt <= lat_set;
    else if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
    if (mem_req && mem_ready && mem_we && !mem_fault) begin
      if (mem_byte) mem[mem_addr[5:2]][{mem_addr[1:0], 3'b000} +: 8] <= mem_wdata[7:0];
      else mem[mem_addr[5:2]] <= mem_wdata;
    end
  end

  function automatic logic [31:0] shift_ref(logic [31:0] v, int k, int a, logic c);
    int e;
    logic [63:0] w;
    e = (a == 0) ? 32 : a;
    case (k)
      0: w = {32'b0, v} << a;
      1: w = {32'b0, v} >> e;
      2: w = {{32{v[31]}}, v} >> e;
      default: w = (a == 0) ? {32'b0, c, v[31:1]} : ({v, v} >> a);
    endcase
    return w[31:0];
  endfunction

  // Behavioural reference, advanced on every rising edge
  logic        m_busy, m_we, m_byte, m_ld, m_wb;
  logic [3:0]  m_rd;
  logic [31:0] m_addr, m_wdata, m_upd;
  logic        e_done, e_rfwe, e_wbwe, e_fault, e_pcmod;
  logic [3:0]  e_waddr;
  logic [31:0] e_wdata, e_wbdata;

  always @(posedge clk) begin
    logic [31:0] off, upd, word;
    if (rst) begin
      m_busy <= 0; e_done <= 0; e_rfwe <= 0; e_wbwe <= 0; e_fault <= 0; e_pcmod <= 0;
    end else begin
      e_done <= 0; e_rfwe <= 0; e_wbwe <= 0; e_fault <= 0; e_pcmod <= 0;
      if (!m_busy) begin
        if (start && !cond_pass) e_done <= 1;
        else if (start) begin
          off = imm_sel ? {20'b0, imm_off} : shift_ref(off_reg, shift_type, shift_amt, carry_in);
          upd = up ? base_val + off : base_val - off;
          m_busy <= 1; m_we <= !is_load; m_byte <= is_byte; m_ld <= is_load;
          m_wb <= writeback; m_rd <= rd_idx; m_upd <= upd;
          m_addr <= pre_index ? upd : base_val;
          m_wdata <= (rd_idx == 4'd15 && pc_adj_en) ? rd_val + 32'd4 : rd_val;
        end
      end else if (mem_ready) begin
        m_busy <= 0; e_done <= 1;
        if (m_ld && m_addr >= 32'd64) e_fault <= 1;
        else begin
          if (m_ld) begin
            word = mem[m_addr[5:2]];
            e_rfwe <= 1; e_waddr <= m_rd; e_pcmod <= (m_rd == 4'd15);
            e_wdata <= m_byte ? {24'b0, word[{m_addr[1:0], 3'b000} +: 8]} : word;
          end
          if (m_wb) begin e_wbwe <= 1; e_wbdata <= m_upd; end
        end
      end
    end
  end

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cmp("R9", "mem_req", {31'b0, mem_req}, {31'b0, m_busy});
      if (m_busy) begin
        cmp("R2", "mem_addr", mem_addr, m_addr);
        cmp("R4", "mem_byte", {31'b0, mem_byte}, {31'b0, m_byte});
        cmp("R6", "mem_we", {31'b0, mem_we}, {31'b0, m_we});
        if (m_we) cmp("R6", "mem_wdata", mem_wdata, m_wdata);
      end
      cmp("R8", "done", {31'b0, done}, {31'b0, e_done});
      cmp("R5", "rf_we", {31'b0, rf_we}, {31'b0, e_rfwe});
      if (e_rfwe) begin
        cmp("R5", "rf_waddr", {28'b0, rf_waddr}, {28'b0, e_waddr});
        cmp("R4", "rf_wdata", rf_wdata, e_wdata);
      end
      cmp("R5", "pc_modified", {31'b0, pc_modified}, {31'b0, e_pcmod});
      cmp("R3", "wb_we", {31'b0, wb_we}, {31'b0, e_wbwe});
      if (e_wbwe) cmp("R3", "wb_data", wb_data, e_wbdata);
      cmp("R7", "fault", {31'b0, fault}, {31'b0, e_fault});
    end
  end

  task automatic issue(bit cp, bit ld, bit byt, bit pre, bit u, bit wb, bit isel,
                       int imm, int st, int sa, int rd, logic [31:0] base,
                       logic [31:0] offr, logic [31:0] rdv, bit cin, int lat);
    @(negedge clk);
    cond_pass = cp; is_load = ld; is_byte = byt; pre_index = pre; up = u;
    writeback = wb; imm_sel = isel; imm_off = 12'(imm); shift_type = 2'(st);
    shift_amt = 5'(sa); rd_idx = 4'(rd); base_val = base; off_reg = offr;
    rd_val = rdv; carry_in = cin; lat_set = lat; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R10: reset state
    cmp("R10", "mem_req", {31'b0, mem_req}, 0);
    cmp("R10", "done/rf_we/wb_we/fault/pc_modified",
        {27'b0, done, rf_we, wb_we, fault, pc_modified}, 0);
    rst = 0;
    // R6/R2/R3: word store, pre-indexed, writeback
    issue(1,0,0,1,1,1,1, 8,0,0, 2, 32'd0, 0, 32'h11223344, 0, 0);
    @(negedge clk); cmp("R6", "mem[8]", mem[2], 32'h11223344);
    // R5/R2/R3: word load, post-indexed, writeback to 12
    issue(1,1,0,0,1,1,1, 4,0,0, 3, 32'd8, 0, 0, 0, 1);
    // R4/R1: byte store, register offset LSL#2 subtracted, latency 2
    issue(1,0,1,1,0,0,0, 0,0,2, 4, 32'd32, 32'd3, 32'h000000A5, 0, 2);
    @(negedge clk); cmp("R4", "byte at 20", {24'b0, mem[5][7:0]}, 32'hA5);
    // R4: byte load zero-extends
    issue(1,1,1,1,1,0,1, 21,0,0, 5, 32'd0, 0, 0, 0, 0);
    issue(1,1,1,1,1,0,1, 20,0,0, 5, 32'd0, 0, 0, 0, 0);
    // R6: R15 stored with and without +4
    pc_adj_en = 1;
    issue(1,0,0,1,1,0,1, 24,0,0, 15, 32'd0, 0, 32'h100, 0, 0);
    pc_adj_en = 0;
    issue(1,0,0,1,1,0,1, 28,0,0, 15, 32'd0, 0, 32'h100, 0, 1);
    @(negedge clk);
    cmp("R6", "r15 store adjusted", mem[6], 32'h104);
    cmp("R6", "r15 store plain", mem[7], 32'h100);
    // R5: load into R15
    issue(1,1,0,1,1,0,1, 24,0,0, 15, 32'd0, 0, 0, 0, 0);
    // R7: faulting load with writeback requested
    issue(1,1,0,1,1,1,1, 0,0,0, 6, 32'h1000, 0, 0, 0, 1);
    // R8: condition fails
    issue(0,0,0,1,1,1,1, 4,0,0, 7, 32'd0, 0, 32'hDEAD, 0, 0);
    @(negedge clk); cmp("R8", "mem[4] untouched", mem[1], 32'h0);
    // R1: shift corner cases (pre-indexed loads with writeback)
    issue(1,1,0,1,1,1,0, 0,3,0, 1, 32'd0, 32'h10, 0, 0, 0);          // RRX -> 8
    issue(1,1,0,1,1,1,0, 0,1,0, 1, 32'd12, 32'hFFFF, 0, 0, 0);       // LSR#32 -> 0
    issue(1,1,0,1,1,1,0, 0,2,0, 1, 32'd40, 32'h80000000, 0, 0, 0);   // ASR#32 -> -1
    issue(1,1,0,1,1,1,0, 0,3,8, 1, 32'd0, 32'h400, 0, 0, 0);         // ROR#8 -> 4
    issue(1,1,0,1,1,1,0, 0,2,4, 1, 32'd50, 32'hFFFFFF00, 0, 0, 0);   // ASR#4 -> -16
    issue(1,1,0,1,1,1,0, 0,3,0, 1, 32'h80000010, 32'h0, 0, 1, 0);    // RRX carry wraps
    issue(1,0,0,0,0,1,0, 0,1,4, 1, 32'd44, 32'h40, 32'h5A5A, 0, 0);  // LSR#4 down, post
    // R9: stray start while busy is ignored
    @(negedge clk);
    cond_pass = 1; is_load = 0; is_byte = 0; pre_index = 1; up = 1; writeback = 0;
    imm_sel = 1; imm_off = 12'd48; rd_idx = 4'd1; base_val = 0; rd_val = 32'hCAFE;
    lat_set = 3; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); imm_off = 12'd52; rd_val = 32'hBEEF; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    cmp("R9", "first store landed", mem[12], 32'hCAFE);
    cmp("R9", "stray start ignored", mem[13], 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule